// File: doc/BRIEF.md
# Tiled 16x16 Matrix-Multiply Sequencer

This block computes D = C + A·B for 16x16 signed matrices. It does the work on small tiles, following a fixed schedule. The result is cut into eight 8x4 chunks, and the chunks are handled one after another. Each chunk covers the K dimension in four sets of four. Each set is split into steps, and one step updates a small rectangle of the chunk in a single clock through a bank of parallel dot-product lanes. A chunk accumulator holds the partial sums across sets. The C term is added when the first set runs. When the last set runs, the finished values move into a result store.

Operands are loaded one element per cycle through a write port while the block is idle. A start pulse launches a run, and an abort pulse cancels it. A done flag marks a result that is complete and valid. The result is read through a registered read port. Two run modes exist:

- **Wide mode** uses 4x2 subchunks, so a set takes four steps. Results are read out with the full 40-bit accumulator.
- **Narrow mode** uses 8x2 subchunks, so a set takes two steps and a run takes half as long. Results are read out clamped to the 16-bit signed range.

Top module: `tiled_mma_seq`

## Requirements
- R1: After a synchronous reset, `busy` and `done` are both low.
- R2: The write port is decoded as follows:
  - `wr_sel` 0 writes A, 1 writes B, 2 writes C, and 3 writes nothing.
  - `wr_addr` is row·16+col.
  - In wide mode, result element (row, col) equals C[row][col] + Σk A[row][k]·B[k][col], as a 40-bit two's-complement value.
  - `rd_data` shows the element at `rd_addr` one clock after the address is applied.
- R3: In wide mode, `busy` stays high for exactly 128 cycles after an accepted start (8 chunks × 4 sets × 4 steps). `done` rises on the same edge where `busy` falls.
- R4: In narrow mode, `busy` stays high for exactly 64 cycles. Each result reads back clamped to [-32768, 32767] and sign-extended to 40 bits.
- R5: An abort while busy drops `busy` at the next edge and leaves `done` low. A later run still gives correct results.
- R6: Writes presented while `busy` is high change no operand.
- R7: A start pulse while busy is ignored. The run length and the mode of the current run stay unchanged.
- R8: `done` stays high until the next accepted start, which clears it.
- R9: C is added exactly once per element. With A all zero, every result equals C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Operand write strobe (honoured only while idle) |
| wr_sel | input | 2 | Target buffer: 0 A, 1 B, 2 C, 3 none |
| wr_addr | input | 8 | Element address row·16+col |
| wr_data | input | 16 | Signed operand value |
| start | input | 1 | Launch a run when idle |
| narrow | input | 1 | Mode captured at start: 1 narrow, 0 wide |
| abort | input | 1 | Cancel the run in progress |
| rd_addr | input | 8 | Result element address row·16+col |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run completed without abort |
| rd_data | output | 40 | Registered result element |

## Verification
The bench builds the block with its default parameters:

- 16x16 matrices
- 16-bit operands and a 40-bit accumulator
- 8x4 chunks, 4x2 subchunks and 4-deep K sets

With these values, runs take 128 or 64 cycles, which is short enough to repeat across many matrix patterns. Full-scale operands cannot wrap the 40-bit sum, yet they drive the narrow-mode clamp hard against both rails. This lets random, all-maximum, most-negative, zero-A and small-value patterns be compared against a plain triple-loop reference in both modes, including after an abort.

// File: rtl/mm_pkg.sv
package mm_pkg;
  typedef enum logic [1:0] {
    SEL_A    = 2'd0,
    SEL_B    = 2'd1,
    SEL_C    = 2'd2,
    SEL_NONE = 2'd3
  } buf_sel_e;
endpackage

// File: rtl/mm_sched.sv
module mm_sched #(
  parameter int NGRP    = 8,
  parameter int NSET    = 4,
  parameter int NSTEP_W = 4,
  parameter int NSTEP_N = 2,
  parameter int GW      = 3,
  parameter int SW      = 2,
  parameter int TW      = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          abort,
  input  logic          narrow,
  output logic          busy,
  output logic          done,
  output logic          nar_q,
  output logic [GW-1:0] grp,
  output logic [SW-1:0] kset,
  output logic [TW-1:0] step
);
  logic step_last, set_last, grp_last;

  assign step_last = (step == (nar_q ? TW'(NSTEP_N - 1) : TW'(NSTEP_W - 1)));
  assign set_last  = (kset == SW'(NSET - 1));
  assign grp_last  = (grp == GW'(NGRP - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      nar_q <= 1'b0;
      grp   <= '0;
      kset  <= '0;
      step  <= '0;
    end else if (!busy) begin
      if (start) begin
        busy  <= 1'b1;
        done  <= 1'b0;
        nar_q <= narrow;
        grp   <= '0;
        kset  <= '0;
        step  <= '0;
      end
    end else if (abort) begin
      busy <= 1'b0;
    end else if (step_last) begin
      step <= '0;
      if (set_last) begin
        kset <= '0;
        if (grp_last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          grp <= grp + 1'b1;
        end
      end else begin
        kset <= kset + 1'b1;
      end
    end else begin
      step <= step + 1'b1;
    end
  end

  // R8: a valid result is never flagged during a run
  a_r8_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R8: done persists until a start is seen
  a_r8_done_hold: assert property (@(posedge clk) disable iff (rst)
    done && !start |=> done);
  // R5: abort cancels without completion
  a_r5_abort_cancel: assert property (@(posedge clk) disable iff (rst)
    busy && abort |=> !busy && !done);
  // R3: completion only follows a run
  a_r3_done_after_run: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(busy));
  // R7: a start during a run neither ends it nor changes its mode
  a_r7_start_ignored: assert property (@(posedge clk) disable iff (rst)
    busy && start && !abort && !(step_last && set_last && grp_last) |=> busy && $stable(nar_q));
endmodule

// File: rtl/mm_lane.sv
module mm_lane #(
  parameter int DIM   = 16,
  parameter int DW    = 16,
  parameter int ACCW  = 40,
  parameter int CH_R  = 8,
  parameter int CH_C  = 4,
  parameter int KS    = 4,
  parameter int SUB_R = 4,
  parameter int SUB_C = 2,
  parameter int LANE  = 0,
  parameter int GW    = 3,
  parameter int SW    = 2,
  parameter int TW    = 2,
  parameter int ADW   = 8,
  parameter int CIW   = 5
) (
  input  logic [GW-1:0]          grp,
  input  logic [SW-1:0]          kset,
  input  logic [TW-1:0]          step,
  input  logic                   narrow,
  input  logic signed [DW-1:0]   a_val [KS],
  input  logic signed [DW-1:0]   b_val [KS],
  output logic                   en,
  output logic [CIW-1:0]         cidx,
  output logic [ADW-1:0]         res_addr,
  output logic [ADW-1:0]         a_addr [KS],
  output logic [ADW-1:0]         b_addr [KS],
  output logic signed [ACCW-1:0] dot
);
  localparam int COLB = CH_C / SUB_C;
  localparam int LR   = LANE / SUB_C;
  localparam int LC   = LANE % SUB_C;
  localparam int GPR  = DIM / CH_C;

  int rc, cc, r, c;

  always_comb begin
    if (narrow) begin
      rc = LR;
      cc = int'(step) * SUB_C + LC;
      en = (LANE < CH_R * SUB_C);
    end else begin
      rc = (int'(step) / COLB) * SUB_R + LR;
      cc = (int'(step) % COLB) * SUB_C + LC;
      en = (LANE < SUB_R * SUB_C);
    end
    r        = (int'(grp) / GPR) * CH_R + rc;
    c        = (int'(grp) % GPR) * CH_C + cc;
    cidx     = CIW'(rc * CH_C + cc);
    res_addr = ADW'(r * DIM + c);
    for (int j = 0; j < KS; j++) begin
      a_addr[j] = ADW'(r * DIM + int'(kset) * KS + j);
      b_addr[j] = ADW'((int'(kset) * KS + j) * DIM + c);
    end
    dot = '0;
    for (int j = 0; j < KS; j++) begin
      dot = dot + ACCW'(a_val[j]) * ACCW'(b_val[j]);
    end
  end
endmodule

// File: rtl/tiled_mma_seq.sv
module tiled_mma_seq #(
  parameter int DIM   = 16,
  parameter int DW    = 16,
  parameter int ACCW  = 40,
  parameter int CH_R  = 8,
  parameter int CH_C  = 4,
  parameter int KS    = 4,
  parameter int SUB_R = 4,
  parameter int SUB_C = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [1:0]                   wr_sel,
  input  logic [$clog2(DIM*DIM)-1:0]   wr_addr,
  input  logic [DW-1:0]                wr_data,
  input  logic                         start,
  input  logic                         narrow,
  input  logic                         abort,
  input  logic [$clog2(DIM*DIM)-1:0]   rd_addr,
  output logic                         busy,
  output logic                         done,
  output logic [ACCW-1:0]              rd_data
);
  import mm_pkg::*;

  localparam int NELEM   = DIM * DIM;
  localparam int ADW     = $clog2(NELEM);
  localparam int CHN     = CH_R * CH_C;
  localparam int CIW     = $clog2(CHN);
  localparam int NGRP    = NELEM / CHN;
  localparam int NSET    = DIM / KS;
  localparam int NSTEP_W = CHN / (SUB_R * SUB_C);
  localparam int NSTEP_N = CH_C / SUB_C;
  localparam int LANES   = CH_R * SUB_C;
  localparam int GW      = $clog2(NGRP);
  localparam int SW      = $clog2(NSET);
  localparam int TW      = $clog2(NSTEP_W);
  localparam logic signed [ACCW-1:0] SAT_HI = ACCW'((longint'(1) <<< (DW - 1)) - 1);
  localparam logic signed [ACCW-1:0] SAT_LO = ~SAT_HI;

  logic signed [DW-1:0]   a_mem [NELEM];
  logic signed [DW-1:0]   b_mem [NELEM];
  logic signed [DW-1:0]   c_mem [NELEM];
  logic signed [ACCW-1:0] res_mem [NELEM];
  logic signed [ACCW-1:0] acc [CHN];

  logic          nar_q;
  logic [GW-1:0] grp;
  logic [SW-1:0] kset;
  logic [TW-1:0] step;
  logic          first_set, last_set;

  logic [LANES-1:0]       lane_en;
  logic [CIW-1:0]         lane_cidx [LANES];
  logic [ADW-1:0]         lane_raddr [LANES];
  logic signed [ACCW-1:0] lane_dot [LANES];
  logic signed [DW-1:0]   lane_cval [LANES];
  logic signed [ACCW-1:0] lane_nv [LANES];

  mm_sched #(
    .NGRP(NGRP), .NSET(NSET), .NSTEP_W(NSTEP_W), .NSTEP_N(NSTEP_N),
    .GW(GW), .SW(SW), .TW(TW)
  ) u_sched (
    .clk(clk), .rst(rst), .start(start), .abort(abort), .narrow(narrow),
    .busy(busy), .done(done), .nar_q(nar_q), .grp(grp), .kset(kset), .step(step)
  );

  assign first_set = (kset == '0);
  assign last_set  = (kset == SW'(NSET - 1));

  // operand load port, locked while a run is active
  always_ff @(posedge clk) begin
    if (wr_en && !busy) begin
      case (buf_sel_e'(wr_sel))
        SEL_A:   a_mem[wr_addr] <= wr_data;
        SEL_B:   b_mem[wr_addr] <= wr_data;
        SEL_C:   c_mem[wr_addr] <= wr_data;
        default: ;
      endcase
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [ADW-1:0]       aa [KS];
    logic [ADW-1:0]       ba [KS];
    logic signed [DW-1:0] av [KS];
    logic signed [DW-1:0] bv [KS];
    for (genvar j = 0; j < KS; j++) begin : g_k
      assign av[j] = a_mem[aa[j]];
      assign bv[j] = b_mem[ba[j]];
    end
    assign lane_cval[l] = c_mem[lane_raddr[l]];

    mm_lane #(
      .DIM(DIM), .DW(DW), .ACCW(ACCW), .CH_R(CH_R), .CH_C(CH_C), .KS(KS),
      .SUB_R(SUB_R), .SUB_C(SUB_C), .LANE(l), .GW(GW), .SW(SW), .TW(TW),
      .ADW(ADW), .CIW(CIW)
    ) u_lane (
      .grp(grp), .kset(kset), .step(step), .narrow(nar_q),
      .a_val(av), .b_val(bv),
      .en(lane_en[l]), .cidx(lane_cidx[l]), .res_addr(lane_raddr[l]),
      .a_addr(aa), .b_addr(ba), .dot(lane_dot[l])
    );
  end

  // C enters on the first set only; later sets add onto the chunk accumulator
  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      lane_nv[l] = (first_set ? ACCW'(lane_cval[l]) : acc[lane_cidx[l]]) + lane_dot[l];
    end
  end

  always_ff @(posedge clk) begin
    if (busy && !abort) begin
      for (int l = 0; l < LANES; l++) begin
        if (lane_en[l]) begin
          acc[lane_cidx[l]] <= lane_nv[l];
          if (last_set) res_mem[lane_raddr[l]] <= lane_nv[l];
        end
      end
    end
  end

  function automatic logic signed [ACCW-1:0] clamp(input logic signed [ACCW-1:0] v);
    if (v > SAT_HI) return SAT_HI;
    if (v < SAT_LO) return SAT_LO;
    return v;
  endfunction

  always_ff @(posedge clk) begin
    rd_data <= nar_q ? clamp(res_mem[rd_addr]) : res_mem[rd_addr];
  end

  // R4: narrow mode doubles the active lanes so a set needs half the steps
  a_r4_lane_count: assert property (@(posedge clk) disable iff (rst)
    busy |-> $countones(lane_en) == (nar_q ? LANES : SUB_R * SUB_C));
endmodule

// File: tb/sim_tiled_mma_seq.sv
`timescale 1ns/1ps
module sim_tiled_mma_seq;
  localparam int NE = 256;
  // bit4 = narrow mode, bits3:0 = operand pattern kind
  localparam logic [7:0] CASES [8] = '{8'h00, 8'h10, 8'h01, 8'h11, 8'h02, 8'h12, 8'h03, 8'h14};

  logic        clk = 1'b0, rst = 1'b1;
  logic        wr_en = 1'b0, start = 1'b0, narrow = 1'b0, abort = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [7:0]  wr_addr = 8'd0, rd_addr = 8'd0;
  logic [15:0] wr_data = 16'd0;
  logic        busy, done;
  logic [39:0] rd_data;

  int     nchk = 0, nerr = 0;
  int     am [NE], bm [NE], cm [NE];
  longint refm [NE];

  tiled_mma_seq u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr),
    .wr_data(wr_data), .start(start), .narrow(narrow), .abort(abort),
    .rd_addr(rd_addr), .busy(busy), .done(done), .rd_data(rd_data)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int hsh(input int a);
    logic [31:0] x;
    x = 32'(a) * 32'h9E3779B1;
    x = x ^ (x >> 16);
    x = x * 32'h85EBCA6B;
    x = x ^ (x >> 13);
    return int'($signed(x[15:0]));
  endfunction

  task automatic fill(input int kind, input int seed);
    for (int i = 0; i < NE; i++) begin
      case (kind)
        1: begin am[i] = 32767;  bm[i] = 32767; cm[i] = 32767;  end
        2: begin am[i] = -32768; bm[i] = 32767; cm[i] = -32768; end
        3: begin am[i] = 0; bm[i] = hsh(seed*4096 + 1024 + i); cm[i] = hsh(seed*4096 + 2048 + i); end
        4: begin
          am[i] = hsh(seed*4096 + i) >>> 9;
          bm[i] = hsh(seed*4096 + 1024 + i) >>> 9;
          cm[i] = hsh(seed*4096 + 2048 + i) >>> 4;
        end
        default: begin
          am[i] = hsh(seed*4096 + i);
          bm[i] = hsh(seed*4096 + 1024 + i);
          cm[i] = hsh(seed*4096 + 2048 + i);
        end
      endcase
    end
  endtask

  task automatic wr1(input logic [1:0] sel, input int addr, input int data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_addr = 8'(addr); wr_data = 16'(data);
  endtask

  task automatic load();
    for (int i = 0; i < NE; i++) wr1(2'd0, i, am[i]);
    for (int i = 0; i < NE; i++) wr1(2'd1, i, bm[i]);
    for (int i = 0; i < NE; i++) wr1(2'd2, i, cm[i]);
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic mkref(input bit nar);
    for (int r = 0; r < 16; r++)
      for (int c = 0; c < 16; c++) begin
        longint s = longint'(cm[r*16 + c]);
        for (int k = 0; k < 16; k++) s += longint'(am[r*16 + k]) * longint'(bm[k*16 + c]);
        if (nar && s > 32767) s = 32767;
        if (nar && s < -32768) s = -32768;
        refm[r*16 + c] = s;
      end
  endtask

  task automatic run(input bit nar, output int cyc);
    @(negedge clk); start = 1'b1; narrow = nar;
    @(negedge clk); start = 1'b0; narrow = 1'b0;
    cyc = 0;
    while (busy) begin cyc++; @(negedge clk); end
  endtask

  task automatic rdchk(input string tag);
    int bad = 0;
    longint fa = 0, fe = 0;
    for (int i = 0; i < NE; i++) begin
      @(negedge clk); rd_addr = 8'(i);
      @(negedge clk);
      if (longint'($signed(rd_data)) != refm[i]) begin
        if (bad == 0) begin fa = longint'($signed(rd_data)); fe = refm[i]; end
        bad++;
      end
    end
    chk(bad == 0, tag, fa, fe);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL R3 watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    int cyc;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R1 busy after reset", longint'(busy), 0);
    chk(done == 1'b0, "R1 done after reset", longint'(done), 0);

    // table of patterns: R2 wide, R4 narrow, R9 zero A
    for (int t = 0; t < 8; t++) begin
      bit nar;
      int kind;
      nar  = CASES[t][4];
      kind = int'(CASES[t][3:0]);
      fill(kind, t + 1);
      load();
      run(nar, cyc);
      chk(cyc == (nar ? 64 : 128), nar ? "R4 narrow run length" : "R3 wide run length",
          cyc, nar ? 64 : 128);
      chk(done == 1'b1, "R3 done after run", longint'(done), 1);
      mkref(nar);
      rdchk(nar ? "R4 narrow result" : (kind == 3 ? "R9 C added once" : "R2 wide result"));
    end

    // R5 abort mid-run
    fill(4, 20);
    load();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (40) @(negedge clk);
    abort = 1'b1;
    @(negedge clk); abort = 1'b0;
    chk(busy == 1'b0, "R5 busy after abort", longint'(busy), 0);
    chk(done == 1'b0, "R5 done after abort", longint'(done), 0);
    repeat (10) @(negedge clk);
    chk(done == 1'b0, "R5 done stays low", longint'(done), 0);
    run(1'b0, cyc);
    chk(cyc == 128, "R5 rerun length", cyc, 128);
    mkref(1'b0);
    rdchk("R5 rerun result");

    // R6 writes while busy are dropped
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    wr1(2'd0, 255, 1234);
    wr1(2'd2, 255, -500);
    wr1(2'd1, 240, 999);
    wr1(2'd0, 128, -77);
    @(negedge clk); wr_en = 1'b0;
    while (busy) @(negedge clk);
    rdchk("R6 locked operands");

    // R7 start while busy ignored
    fill(0, 30);
    load();
    @(negedge clk); start = 1'b1; narrow = 1'b0;
    @(negedge clk); start = 1'b0;
    cyc = 0;
    while (busy) begin
      cyc++;
      start  = (cyc == 10);
      narrow = (cyc == 10);
      @(negedge clk);
    end
    start = 1'b0; narrow = 1'b0;
    chk(cyc == 128, "R7 run length with extra start", cyc, 128);
    mkref(1'b0);
    rdchk("R7 mode kept");

    // R2 select code 3 writes nothing
    wr1(2'd3, 0, 16'h0777);
    wr1(2'd3, 17, -1);
    @(negedge clk); wr_en = 1'b0;
    run(1'b0, cyc);
    rdchk("R2 select 3 ignored");

    // R8 done held then cleared by start
    repeat (20) @(negedge clk);
    chk(done == 1'b1, "R8 done held", longint'(done), 1);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(done == 1'b0, "R8 done cleared by start", longint'(done), 0);
    chk(busy == 1'b1, "R8 run accepted", longint'(busy), 1);
    while (busy) @(negedge clk);
    chk(done == 1'b1, "R8 done after second run", longint'(done), 1);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule